// File: doc/BRIEF.md
# Half-Bridge Output Controller

This block turns per-output switch requests into eight driver enable lines. Six of the lines form three half-bridges, each with a low-side and a high-side switch. The last two lines drive high-side-only outputs. A register interface outside the block supplies one on/off bit and one PWM-enable bit for each output. When an output's PWM-enable bit is set, the output conducts only while the shared PWM input is high.

The block protects the power stage in two ways. On each half-bridge, a hardware interlock never lets both switches conduct together. It also inserts a fixed number of dead cycles whenever conduction moves from one switch of the bridge to the other.

Each output has its own synchronously sampled over-current flag. A flag latches a status bit for that output and turns its driver off. Recovery then follows one of two modes:
- **Manual mode:** the driver stays off until the register interface sends a clear request for that output.
- **Retry mode:** the block waits through an off window, then lets the driver run through an on window. The lengths of both windows come from a 4-bit duty code, so a persistent fault gives a pulsed current.

Top module: `pwr_stage_ctrl`

## Requirements
- R1: Vector bit i belongs to one output in every vector port. Bits 0 and 1 are the low and high switch of bridge 1, bits 2 and 3 those of bridge 2, and bits 4 and 5 those of bridge 3. Bits 6 and 7 are the two high-side-only outputs.
- R2: An output with no latched fault and no interlock hold conducts exactly when its on/off bit is 1 and either its PWM-enable bit is 0 or `pwm_in` is 1. The output enable is combinational in these inputs.
- R3: When both the low and the high request of one bridge are active, both switches of that bridge stay off.
- R4: When a bridge hands conduction from one switch to the other, both switches stay off for `DEAD_CYC` cycles. No gap is inserted when the same switch turns on again, and none on the high-side-only outputs.
- R5: An over-current flag seen at a clock edge sets that output's status bit. The driver is off from the cycle after that edge.
- R6: With `retry_en` at 0, a latched output stays off and keeps its status bit until a clear request for that output arrives. The output may conduct again from the cycle after that request's edge.
- R7: With `retry_en` at 1, the output stays off for (16 - duty_code) * `BASE_CYC` cycles after the edge that saw the flag. It then may conduct, with its status still set, for (duty_code + 1) * `BASE_CYC` cycles, after which the status bit clears by itself. A new flag during the on window restarts the off window.
- R8: When a flag and a clear request for the same output meet at one edge, the flag wins and the status bit ends set.
- R9: A synchronous reset clears every status bit and forgets past bridge conduction. Right after reset, either switch of a bridge may turn on with no dead gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_bits | input | 8 | Per-output switch request from the register interface |
| pwm_en | input | 8 | Per-output PWM gating enable |
| pwm_in | input | 1 | Shared external PWM signal |
| retry_en | input | 1 | 1 selects automatic retry recovery, 0 selects manual clear |
| duty_code | input | 4 | Retry duty code that sets the off and on window lengths |
| oc_flag | input | 8 | Per-output over-current flag, sampled at the clock edge |
| oc_clear | input | 8 | Per-output clear request for the latched status bit |
| drv_on | output | 8 | Driver enable for each switch |
| oc_status | output | 8 | Latched over-current status for each output |

## Verification
A fault flag and a clear request can reach the same output in the same cycle. The bench provokes this on every output by raising `oc_flag` and `oc_clear` together in one cycle, after the output has already latched a fault in manual mode. It then judges the result at the ports: the status bit must still be set and the driver must still be off, and only a later lone clear may restore conduction. A second overlap comes from a fresh flag landing inside a retry on window. The bench checks that the off window restarts with its full computed length.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {SIDE_NONE = 2'd0, SIDE_LO = 2'd1, SIDE_HI = 2'd2} side_e;
  typedef enum logic [1:0] {REC_IDLE = 2'd0, REC_OFF = 2'd1, REC_ON = 2'd2} rec_e;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned CODE_SPAN = 1 << CODE_W;

  // cycles the driver is held off after a fault in retry mode
  function automatic int unsigned rec_off_len(input logic [CODE_W-1:0] code,
                                              input int unsigned base);
    return (CODE_SPAN - 32'(code)) * base;
  endfunction

  // cycles the driver may run before the status self-clears
  function automatic int unsigned rec_on_len(input logic [CODE_W-1:0] code,
                                             input int unsigned base);
    return (32'(code) + 1) * base;
  endfunction
endpackage

// File: rtl/oc_guard.sv
module oc_guard
  import psc_pkg::*;
#(
  parameter int unsigned BASE_CYC = 4,
  localparam int unsigned CNT_W = $clog2(CODE_SPAN * BASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flag,
  input  logic              clear,
  input  logic              retry,
  input  logic [CODE_W-1:0] code,
  output logic              status,
  output logic              allow,
  output logic              rec_on
);
  rec_e             st;
  logic [CNT_W-1:0] cnt;
  logic             stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= REC_IDLE;
      stat_q <= 1'b0;
      cnt    <= '0;
    end else if (flag) begin
      stat_q <= 1'b1;
      cnt    <= CNT_W'(rec_off_len(code, BASE_CYC) - 1);
      st     <= retry ? REC_OFF : REC_IDLE;
    end else if (clear) begin
      stat_q <= 1'b0;
      st     <= REC_IDLE;
      cnt    <= '0;
    end else begin
      case (st)
        REC_OFF: begin
          if (cnt == '0) begin
            st  <= REC_ON;
            cnt <= CNT_W'(rec_on_len(code, BASE_CYC) - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        REC_ON: begin
          if (cnt == '0) begin
            st     <= REC_IDLE;
            stat_q <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign status = stat_q;
  assign rec_on = (st == REC_ON);
  assign allow  = !stat_q || rec_on;
endmodule

// File: rtl/bridge_lock.sv
module bridge_lock
  import psc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2,
  localparam int unsigned DW = $clog2(DEAD_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic want_lo,
  input  logic want_hi,
  output logic on_lo,
  output logic on_hi
);
  side_e         last;
  logic [DW-1:0] gap;
  logic          dead_ok;

  assign dead_ok = (gap >= DW'(DEAD_CYC));
  assign on_lo   = want_lo && !want_hi && ((last != SIDE_HI) || dead_ok);
  assign on_hi   = want_hi && !want_lo && ((last != SIDE_LO) || dead_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      last <= SIDE_NONE;
      gap  <= DW'(DEAD_CYC);
    end else if (on_lo) begin
      last <= SIDE_LO;
      gap  <= '0;
    end else if (on_hi) begin
      last <= SIDE_HI;
      gap  <= '0;
    end else if (!dead_ok) begin
      gap <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_stage_ctrl.sv
module pwr_stage_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned NUM_BRIDGE = 3,
  parameter int unsigned NUM_HSONLY = 2,
  parameter int unsigned DEAD_CYC   = 2,
  parameter int unsigned BASE_CYC   = 4,
  localparam int unsigned NUM_OUT = 2 * NUM_BRIDGE + NUM_HSONLY
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] on_bits,
  input  logic [NUM_OUT-1:0] pwm_en,
  input  logic               pwm_in,
  input  logic               retry_en,
  input  logic [CODE_W-1:0]  duty_code,
  input  logic [NUM_OUT-1:0] oc_flag,
  input  logic [NUM_OUT-1:0] oc_clear,
  output logic [NUM_OUT-1:0] drv_on,
  output logic [NUM_OUT-1:0] oc_status
);
  logic [NUM_OUT-1:0] req;     // request after PWM gating
  logic [NUM_OUT-1:0] allow;   // fault logic permits conduction
  logic [NUM_OUT-1:0] rec_on;  // in retry on window
  logic [NUM_OUT-1:0] want;    // request surviving fault logic

  assign req  = on_bits & (~pwm_en | {NUM_OUT{pwm_in}});
  assign want = req & allow;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_guard
    oc_guard #(.BASE_CYC(BASE_CYC)) u_guard (
      .clk    (clk),
      .rst    (rst),
      .flag   (oc_flag[g]),
      .clear  (oc_clear[g]),
      .retry  (retry_en),
      .code   (duty_code),
      .status (oc_status[g]),
      .allow  (allow[g]),
      .rec_on (rec_on[g])
    );
  end

  for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
    bridge_lock #(.DEAD_CYC(DEAD_CYC)) u_lock (
      .clk     (clk),
      .rst     (rst),
      .want_lo (want[2*b]),
      .want_hi (want[2*b+1]),
      .on_lo   (drv_on[2*b]),
      .on_hi   (drv_on[2*b+1])
    );
  end

  for (genvar h = 0; h < NUM_HSONLY; h++) begin : g_hsonly
    assign drv_on[2*NUM_BRIDGE+h] = want[2*NUM_BRIDGE+h];
  end
endmodule

// File: rtl/pwr_stage_chk.sv
module pwr_stage_chk #(
  parameter int unsigned NUM_BRIDGE = 3,
  parameter int unsigned NUM_HSONLY = 2,
  parameter int unsigned DEAD_CYC   = 2,
  localparam int unsigned NUM_OUT = 2 * NUM_BRIDGE + NUM_HSONLY
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OUT-1:0] on_bits,
  input logic [NUM_OUT-1:0] pwm_en,
  input logic               pwm_in,
  input logic [NUM_OUT-1:0] oc_flag,
  input logic [NUM_OUT-1:0] oc_clear,
  input logic [NUM_OUT-1:0] drv_on,
  input logic [NUM_OUT-1:0] oc_status,
  input logic [NUM_OUT-1:0] rec_on
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    AST_GATE_ON: assert property (@(posedge clk) disable iff (rst)
      drv_on[i] |-> on_bits[i] && (!pwm_en[i] || pwm_in)); // R2
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
      oc_flag[i] |=> oc_status[i]); // R8
    AST_FLAG_CUTS: assert property (@(posedge clk) disable iff (rst)
      oc_flag[i] |=> !drv_on[i]); // R5
    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
      oc_status[i] && !rec_on[i] && !oc_clear[i] |=> oc_status[i]); // R6
    AST_BLOCK_LATCH: assert property (@(posedge clk) disable iff (rst)
      oc_status[i] && !rec_on[i] |-> !drv_on[i]); // R6
    AST_RETRY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
      rec_on[i] |-> oc_status[i]); // R7
  end

  for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_br
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
      !(drv_on[2*b] && drv_on[2*b+1])); // R3
    if (DEAD_CYC > 0) begin : g_dead
      AST_DEAD_LO_HI: assert property (@(posedge clk) disable iff (rst)
        drv_on[2*b] |=> !drv_on[2*b+1]); // R4
      AST_DEAD_HI_LO: assert property (@(posedge clk) disable iff (rst)
        drv_on[2*b+1] |=> !drv_on[2*b]); // R4
    end
  end
endmodule

bind pwr_stage_ctrl pwr_stage_chk #(
  .NUM_BRIDGE (NUM_BRIDGE),
  .NUM_HSONLY (NUM_HSONLY),
  .DEAD_CYC   (DEAD_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .on_bits   (on_bits),
  .pwm_en    (pwm_en),
  .pwm_in    (pwm_in),
  .oc_flag   (oc_flag),
  .oc_clear  (oc_clear),
  .drv_on    (drv_on),
  .oc_status (oc_status),
  .rec_on    (rec_on)
);

// File: tb/pwr_stage_ctrl_test.sv
`timescale 1ns/1ps
module pwr_stage_ctrl_test;
  localparam int DEAD = 2;
  localparam int BASE = 4;
  localparam int NO   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NO-1:0] on_bits = '0, pwm_en = '0, oc_flag = '0, oc_clear = '0;
  logic          pwm_in = 1'b0, retry_en = 1'b0;
  logic [3:0]    duty_code = 4'd0;
  logic [NO-1:0] drv_on, oc_status;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwr_stage_ctrl #(.NUM_BRIDGE(3), .NUM_HSONLY(2), .DEAD_CYC(DEAD), .BASE_CYC(BASE)) uut (
    .clk(clk), .rst(rst), .on_bits(on_bits), .pwm_en(pwm_en), .pwm_in(pwm_in),
    .retry_en(retry_en), .duty_code(duty_code), .oc_flag(oc_flag),
    .oc_clear(oc_clear), .drv_on(drv_on), .oc_status(oc_status)
  );

  function automatic int exp_off(input int c);
    return BASE * 16 - BASE * c;
  endfunction
  function automatic int exp_on(input int c);
    return BASE * c + BASE;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt(input int n);
    for (int j = 0; j < n; j++) @(negedge clk);
  endtask

  task automatic idle_all();
    @(negedge clk);
    on_bits = '0; pwm_en = '0; pwm_in = 1'b0; oc_flag = '0; oc_clear = '0;
    nxt(DEAD + 2);
  endtask

  initial begin
    #(100000 * 5);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    nxt(3);
    rst = 1'b0;
    #1;
    chk("R9 reset status", 32'(oc_status), 32'h0);
    chk("R9 reset drive", 32'(drv_on), 32'h0);

    // R1 R2: each output alone, all gating combinations
    for (int i = 0; i < NO; i++) begin
      idle_all();
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        on_bits = NO'(p & 1) << i;
        pwm_en  = NO'((p >> 1) & 1) << i;
        pwm_in  = ((p >> 2) & 1) != 0;
        #1;
        chk("R1 R2 gating", 32'(drv_on),
            32'(NO'((p & 1) & (((~p >> 1) & 1) | ((p >> 2) & 1))) << i));
      end
    end

    // R3: both requests on one bridge
    for (int b = 0; b < 3; b++) begin
      idle_all();
      on_bits = NO'(3) << (2 * b);
      #1;
      chk("R3 both off", 32'(drv_on), 32'h0);
    end

    // R4: dead gap on direction change, none on repeat or high-only
    for (int b = 0; b < 3; b++) begin
      idle_all();
      on_bits = NO'(1) << (2 * b);
      #1 chk("R4 lo on", 32'(drv_on), 32'(NO'(1) << (2 * b)));
      @(negedge clk);
      on_bits = NO'(2) << (2 * b);
      for (int k = 0; k <= DEAD; k++) begin
        #1 chk("R4 dead gap", 32'(drv_on), (k == DEAD) ? 32'(NO'(2) << (2 * b)) : 32'h0);
        @(negedge clk);
      end
      on_bits = '0;
      @(negedge clk);
      on_bits = NO'(2) << (2 * b);
      #1 chk("R4 same side no gap", 32'(drv_on), 32'(NO'(2) << (2 * b)));
    end
    idle_all();
    on_bits = 8'h40;
    @(negedge clk);
    on_bits = 8'h80;
    #1 chk("R4 high-only no gap", 32'(drv_on), 32'h80);

    // R5 R6 R8: manual recovery on every output
    retry_en = 1'b0;
    for (int i = 0; i < NO; i++) begin
      idle_all();
      on_bits = NO'(1) << i;
      #1 chk("R2 on before fault", 32'(drv_on), 32'(NO'(1) << i));
      oc_flag = NO'(1) << i;
      @(negedge clk);
      oc_flag = '0;
      #1;
      chk("R5 status set", 32'(oc_status), 32'(NO'(1) << i));
      chk("R5 driver off", 32'(drv_on), 32'h0);
      nxt(5);
      #1;
      chk("R6 held status", 32'(oc_status), 32'(NO'(1) << i));
      chk("R6 held off", 32'(drv_on), 32'h0);
      @(negedge clk);
      oc_flag = NO'(1) << i;
      oc_clear = NO'(1) << i;
      @(negedge clk);
      oc_flag = '0; oc_clear = '0;
      #1;
      chk("R8 flag beats clear status", 32'(oc_status), 32'(NO'(1) << i));
      chk("R8 flag beats clear drive", 32'(drv_on), 32'h0);
      @(negedge clk);
      oc_clear = NO'(1) << i;
      @(negedge clk);
      oc_clear = '0;
      #1;
      chk("R6 cleared status", 32'(oc_status), 32'h0);
      chk("R6 cleared drive", 32'(drv_on), 32'(NO'(1) << i));
    end

    // R9: reset clears latched status and bridge history
    idle_all();
    on_bits = 8'h01;
    oc_flag = 8'h40;
    @(negedge clk);
    oc_flag = '0;
    #1 chk("R9 pre-reset latch", 32'(oc_status), 32'h40);
    @(negedge clk);
    on_bits = '0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; on_bits = 8'h02;
    #1;
    chk("R9 status cleared", 32'(oc_status), 32'h0);
    chk("R9 no gap after reset", 32'(drv_on), 32'h02);

    // R7: retry timing for every duty code
    idle_all();
    retry_en = 1'b1;
    on_bits = 8'h80;
    for (int c = 0; c < 16; c++) begin
      duty_code = 4'(c);
      nxt(2);
      oc_flag = 8'h80;
      @(negedge clk);
      oc_flag = '0;
      for (int k = 1; k <= exp_off(c) + exp_on(c) + 1; k++) begin
        #1;
        chk("R7 retry drive", 32'(drv_on[7]), 32'(k > exp_off(c)));
        chk("R7 retry status", 32'(oc_status[7]), 32'(k <= exp_off(c) + exp_on(c)));
        @(negedge clk);
      end
    end

    // R7: new fault inside the on window restarts the off window
    duty_code = 4'd5;
    nxt(2);
    oc_flag = 8'h80;
    @(negedge clk);
    oc_flag = '0;
    nxt(exp_off(5) + 1);
    #1 chk("R7 in on window", 32'(drv_on[7]), 32'h1);
    oc_flag = 8'h80;
    @(negedge clk);
    oc_flag = '0;
    for (int k = 1; k <= exp_off(5) + 1; k++) begin
      #1 chk("R7 restarted off window", 32'(drv_on[7]), 32'(k > exp_off(5)));
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule